// File: doc/BRIEF.md
# PLL Bring-Up and Idle Sequencer

This block starts and stops a PHY's digital PLL without software help. On a start-up request it reads the PLL control registers through a 32-bit register-bus master port. If the PLL is parked in idle, the block takes it out of idle. If the PLL is not yet locked, it writes the divider settings as read-modify-write cycles, triggers the PLL and polls for lock. On a shutdown request it parks the PLL in idle and waits until both power-down status flags are raised.

The divider settings come from an internal table. A mode input selects the USB or SATA table, and a 3-bit code selects the reference clock rate. Every wait on a status bit is bounded by a cycle counter. Each request ends with a one-cycle done pulse. A 2-bit result code is held until the next request is accepted.

Top module: `pll_bringup_seq`

## Requirements
- R1: After a synchronous active-low reset, `done`, `busy`, `err_code` and `bus_valid` are all 0.
- R2: The bus port has at most one access outstanding. Once `bus_valid` is raised, it stays high with `bus_addr`, `bus_write` and `bus_wdata` unchanged until a cycle in which `bus_ready` is high. That cycle completes the access, and read data is taken from `bus_rdata` in the same cycle.
- R3: `rate_sel` codes 0 to 5 select 12, 16.8, 19.2, 20, 26 and 38.4 MHz. Codes 6 and 7 are invalid. A start-up request with an invalid code issues no bus access and finishes with `err_code` 1.
- R4: On start-up the block reads config2 (offset 0x10). If bit 0 (idle) is set, it writes config2 back with bit 0 cleared and every other bit kept, then polls status (offset 0x04) for lock (bit 1).
- R5: Next the block reads status. If lock is set, it writes no divider field and finishes with `err_code` 0.
- R6: If lock is clear, the block programs five fields, each with a read followed by a write that keeps all bits outside the field. The order is: N into config1 (0x0C) bits 8:1; DCO select into config2 bits 3:1; M into config1 bits 20:9; fractional M into config4 (0x20) bits 17:0; sigma-delta into config3 (0x14) bits 17:10.
- R7: USB table (M, N, DCO, SD, fracM), by rate: 12 MHz (1250,5,4,20,0); 16.8 MHz (3125,20,4,20,0); 19.2 MHz (1172,8,4,20,65537); 20 MHz (1000,7,4,10,0); 26 MHz (1250,12,4,20,0); 38.4 MHz (3125,47,4,20,92843). The SATA table uses N=7, DCO=4, SD=6 and fracM=0 at every rate, with M = 1000, 714, 625, 600, 461 and 312.
- R8: After the five fields, the block writes 1 to the go register (0x08) and polls status. When lock is seen it finishes with `err_code` 0. If lock is still clear after `TIMEOUT_CYCLES` cycles of polling, it finishes with `err_code` 2. A timeout during the idle-exit wait also yields code 2.
- R9: A USB-mode shutdown sets config2 bit 0 by read-modify-write, then polls status until bits 15 and 16 are both set, and finishes with `err_code` 0.
- R10: If either status bit 15 or 16 is still clear after `TIMEOUT_CYCLES` cycles of shutdown polling, the block finishes with `err_code` 3.
- R11: A SATA-mode (`mode_sata`=1) shutdown finishes with no bus access and `err_code` 0.
- R12: `done` is high for exactly one cycle at the end of each request. `busy` is high from acceptance until that cycle and low after it. `err_code` holds its value until the next request is accepted, which clears it. Requests are ignored while busy, and start wins over stop when both arrive together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Start-up request, sampled while idle |
| stop_req | input | 1 | Shutdown request, sampled while idle |
| mode_sata | input | 1 | 1 selects the SATA table and SATA shutdown behaviour |
| rate_sel | input | 3 | Encoded reference clock rate |
| bus_valid | output | 1 | Access request on the register bus |
| bus_write | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | 8 | Register byte offset |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Target completes the access this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A request is in progress |
| err_code | output | 2 | 0 ok, 1 invalid rate, 2 lock timeout, 3 power-down timeout |

## Verification
The assertions check on every cycle that the bus handshake holds its request stable and that no access appears while idle. They also check that every address is one of the six register offsets, that any go write carries the value 1, that `done` is a single-cycle pulse that ends `busy`, and that `err_code` changes only when a request is accepted or completes. The ordering of the five field writes, the preservation of neighbouring bits, the table values, the skip paths and the two timeout codes depend on register contents. Only the bench's scenarios can show these, using a register model whose lock and power-down responses are switched on or off per test.

// File: rtl/pll_seq_pkg.sv
// Package: shared types, register offsets and field layout for the PLL
// sequencer. Assumes 8-bit byte offsets and 32-bit registers.
package pll_seq_pkg;

    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_GO   = 8'h08;
    localparam logic [7:0] OFS_CFG1 = 8'h0C;
    localparam logic [7:0] OFS_CFG2 = 8'h10;
    localparam logic [7:0] OFS_CFG3 = 8'h14;
    localparam logic [7:0] OFS_CFG4 = 8'h20;

    localparam int LOCK_BIT  = 1;
    localparam int IDLE_BIT  = 0;
    localparam int PWDN_LO   = 15;
    localparam int PWDN_HI   = 16;
    localparam int NUM_STEPS = 5;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_BADRATE = 2'd1,
        RES_NOLOCK  = 2'd2,
        RES_NOPWDN  = 2'd3
    } result_e;

    typedef struct packed {
        logic [11:0] mult;
        logic [7:0]  div;
        logic [2:0]  dco;
        logic [7:0]  sdv;
        logic [17:0] frac;
    } pll_cfg_t;

    // Register offset written by each programming step, in fixed order.
    function automatic logic [7:0] step_ofs(input logic [2:0] s);
        case (s)
            3'd0:    step_ofs = OFS_CFG1;
            3'd1:    step_ofs = OFS_CFG2;
            3'd2:    step_ofs = OFS_CFG1;
            3'd3:    step_ofs = OFS_CFG4;
            default: step_ofs = OFS_CFG3;
        endcase
    endfunction

    // Bit mask covering the field of each programming step.
    function automatic logic [31:0] step_mask(input logic [2:0] s);
        case (s)
            3'd0:    step_mask = 32'h0000_01FE;
            3'd1:    step_mask = 32'h0000_000E;
            3'd2:    step_mask = 32'h001F_FE00;
            3'd3:    step_mask = 32'h0003_FFFF;
            default: step_mask = 32'h0003_FC00;
        endcase
    endfunction

    // Field value already shifted into place for each step.
    function automatic logic [31:0] step_field(input logic [2:0] s, input pll_cfg_t c);
        case (s)
            3'd0:    step_field = {23'd0, c.div, 1'b0};
            3'd1:    step_field = {28'd0, c.dco, 1'b0};
            3'd2:    step_field = {11'd0, c.mult, 9'd0};
            3'd3:    step_field = {14'd0, c.frac};
            default: step_field = {14'd0, c.sdv, 10'd0};
        endcase
    endfunction

endpackage

// File: rtl/pll_param_rom.sv
// Divider parameter lookup. Pure combinational; assumes rate codes 0..5
// are the defined rates and all other codes are invalid.
module pll_param_rom
    import pll_seq_pkg::*;
#(
    parameter int RATE_W = 3
) (
    input  logic              sata,
    input  logic [RATE_W-1:0] rate,
    output pll_cfg_t          cfg,
    output logic              valid
);
    localparam int NUM_RATES = 6;

    // Select the table row for the mode and rate.
    always_comb begin
        cfg   = '0;
        valid = (int'(rate) < NUM_RATES);
        if (sata) begin
            cfg.div = 8'd7;
            cfg.dco = 3'd4;
            cfg.sdv = 8'd6;
            case (int'(rate))
                0: cfg.mult = 12'd1000;
                1: cfg.mult = 12'd714;
                2: cfg.mult = 12'd625;
                3: cfg.mult = 12'd600;
                4: cfg.mult = 12'd461;
                5: cfg.mult = 12'd312;
                default: cfg = '0;
            endcase
        end else begin
            cfg.dco = 3'd4;
            cfg.sdv = 8'd20;
            case (int'(rate))
                0: begin cfg.mult = 12'd1250; cfg.div = 8'd5;  end
                1: begin cfg.mult = 12'd3125; cfg.div = 8'd20; end
                2: begin cfg.mult = 12'd1172; cfg.div = 8'd8;  cfg.frac = 18'd65537; end
                3: begin cfg.mult = 12'd1000; cfg.div = 8'd7;  cfg.sdv = 8'd10; end
                4: begin cfg.mult = 12'd1250; cfg.div = 8'd12; end
                5: begin cfg.mult = 12'd3125; cfg.div = 8'd47; cfg.frac = 18'd92843; end
                default: cfg = '0;
            endcase
        end
    end
endmodule

// File: rtl/pll_bus_port.sv
// Single-outstanding register bus master. Latches a request pulse, holds
// valid until ready, then returns the read data with a one-cycle pulse.
// Assumes the requester issues a new pulse only after the response.
module pll_bus_port #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp,
    output logic [DW-1:0] rsp_data,
    output logic          bus_valid,
    output logic          bus_write,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ready,
    input  logic [DW-1:0] bus_rdata
);
    // Hold the access until the target accepts it, then report it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_valid <= 1'b0;
            bus_write <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            rsp       <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp <= 1'b0;
            if (bus_valid) begin
                if (bus_ready) begin
                    bus_valid <= 1'b0;
                    rsp       <= 1'b1;
                    rsp_data  <= bus_rdata;
                end
            end else if (req) begin
                bus_valid <= 1'b1;
                bus_write <= req_wr;
                bus_addr  <= req_addr;
                bus_wdata <= req_wdata;
            end
        end
    end
endmodule

// File: rtl/pll_wait_timer.sv
// Poll window counter. Counts while enabled, clears when not, and flags
// expiry once LIMIT cycles have elapsed. Saturates at the limit.
module pll_wait_timer #(
    parameter int LIMIT = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TERM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Count the cycles spent in the current poll window.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  cnt <= '0;
        else if (cnt != TERM) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == TERM);
endmodule

// File: rtl/pll_bringup_seq.sv
// PLL start-up / shutdown sequencer. Walks the idle exit, lock check,
// five-step read-modify-write programming, go trigger and lock poll, or
// the idle entry and power-down poll. Assumes the register target answers
// every access eventually; each status poll is bounded by TIMEOUT_CYCLES.
module pll_bringup_seq
    import pll_seq_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 10_000_000,
    parameter int RATE_W         = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              mode_sata,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [7:0]        bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ready,
    input  logic [31:0]       bus_rdata,
    output logic              done,
    output logic              busy,
    output logic [1:0]        err_code
);
    typedef enum logic [3:0] {
        S_IDLE, S_UP_RCFG, S_UP_WCFG, S_UP_POLL, S_UP_RSTAT,
        S_PG_RD, S_PG_WR, S_PG_GO, S_PG_POLL,
        S_DN_RCFG, S_DN_WCFG, S_DN_POLL, S_FIN
    } st_e;

    st_e         st;
    logic        pending, soft_fail;
    logic [2:0]  step;
    logic [31:0] rd_q;
    logic        rsp;
    logic [31:0] rsp_data;
    logic        req, req_wr;
    logic [7:0]  req_addr;
    logic [31:0] req_wdata;
    logic        in_poll, tmo;
    pll_cfg_t    cfg, cfg_q;
    logic        cfg_ok;
    logic        locked, pwdn_ok;

    pll_param_rom #(.RATE_W(RATE_W)) u_rom (
        .sata(mode_sata), .rate(rate_sel), .cfg(cfg), .valid(cfg_ok)
    );

    pll_bus_port #(.AW(8), .DW(32)) u_port (
        .clk(clk), .rst_n(rst_n),
        .req(req), .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp(rsp), .rsp_data(rsp_data),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
    );

    assign in_poll = (st == S_UP_POLL) || (st == S_PG_POLL) || (st == S_DN_POLL);

    pll_wait_timer #(.LIMIT(TIMEOUT_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(in_poll), .expired(tmo)
    );

    assign locked  = rsp_data[LOCK_BIT];
    assign pwdn_ok = rsp_data[PWDN_LO] && rsp_data[PWDN_HI];
    assign busy    = (st != S_IDLE);
    assign done    = (st == S_FIN);

    // Decode the bus access that belongs to the current state.
    always_comb begin
        req_wr    = 1'b0;
        req_addr  = OFS_STAT;
        req_wdata = '0;
        case (st)
            S_UP_RCFG, S_DN_RCFG: req_addr = OFS_CFG2;
            S_UP_WCFG: begin req_wr = 1'b1; req_addr = OFS_CFG2; req_wdata = rd_q & ~32'h1; end
            S_DN_WCFG: begin req_wr = 1'b1; req_addr = OFS_CFG2; req_wdata = rd_q | 32'h1; end
            S_PG_RD:   req_addr = step_ofs(step);
            S_PG_WR: begin
                req_wr    = 1'b1;
                req_addr  = step_ofs(step);
                req_wdata = (rd_q & ~step_mask(step)) | (step_field(step, cfg_q) & step_mask(step));
            end
            S_PG_GO: begin req_wr = 1'b1; req_addr = OFS_GO; req_wdata = 32'h1; end
            default: ;
        endcase
        req = (st != S_IDLE) && (st != S_FIN) && !pending;
    end

    // Advance the sequence on each bus response and record the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            pending   <= 1'b0;
            soft_fail <= 1'b0;
            step      <= '0;
            rd_q      <= '0;
            cfg_q     <= '0;
            err_code  <= RES_OK;
        end else begin
            if (req) pending <= 1'b1;
            if (rsp) pending <= 1'b0;
            case (st)
                S_IDLE: begin
                    soft_fail <= 1'b0;
                    step      <= '0;
                    if (start_req) begin
                        err_code <= RES_OK;
                        cfg_q    <= cfg;
                        if (!cfg_ok) begin
                            err_code <= RES_BADRATE;
                            st       <= S_FIN;
                        end else st <= S_UP_RCFG;
                    end else if (stop_req) begin
                        err_code <= RES_OK;
                        st       <= mode_sata ? S_FIN : S_DN_RCFG;
                    end
                end
                S_UP_RCFG: if (rsp) begin
                    rd_q <= rsp_data;
                    st   <= rsp_data[IDLE_BIT] ? S_UP_WCFG : S_UP_RSTAT;
                end
                S_UP_WCFG: if (rsp) st <= S_UP_POLL;
                S_UP_POLL: if (rsp) begin
                    if (!locked && tmo) soft_fail <= 1'b1;
                    if (locked || tmo)  st <= S_UP_RSTAT;
                end
                S_UP_RSTAT: if (rsp) begin
                    if (locked) begin
                        err_code <= soft_fail ? RES_NOLOCK : RES_OK;
                        st       <= S_FIN;
                    end else st <= S_PG_RD;
                end
                S_PG_RD: if (rsp) begin
                    rd_q <= rsp_data;
                    st   <= S_PG_WR;
                end
                S_PG_WR: if (rsp) begin
                    if (int'(step) == NUM_STEPS - 1) st <= S_PG_GO;
                    else begin
                        step <= step + 1'b1;
                        st   <= S_PG_RD;
                    end
                end
                S_PG_GO: if (rsp) st <= S_PG_POLL;
                S_PG_POLL: if (rsp) begin
                    if (locked) begin
                        err_code <= soft_fail ? RES_NOLOCK : RES_OK;
                        st       <= S_FIN;
                    end else if (tmo) begin
                        err_code <= RES_NOLOCK;
                        st       <= S_FIN;
                    end
                end
                S_DN_RCFG: if (rsp) begin
                    rd_q <= rsp_data;
                    st   <= S_DN_WCFG;
                end
                S_DN_WCFG: if (rsp) st <= S_DN_POLL;
                S_DN_POLL: if (rsp) begin
                    if (pwdn_ok) st <= S_FIN;
                    else if (tmo) begin
                        err_code <= RES_NOPWDN;
                        st       <= S_FIN;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// Checker: protocol and completion properties of the sequencer ports.
module pll_bringup_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_req,
    input logic        stop_req,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_ready,
    input logic        done,
    input logic        busy,
    input logic [1:0]  err_code
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata))); // R2
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_valid); // R12
    AST_LEGAL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_addr == 8'h04 || bus_addr == 8'h08 || bus_addr == 8'h0C ||
                       bus_addr == 8'h10 || bus_addr == 8'h14 || bus_addr == 8'h20)); // R6
    AST_GO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == 8'h08) |-> (bus_wdata == 32'h1)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R12
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_req && !stop_req) |=> $stable(err_code)); // R12
endmodule

bind pll_bringup_seq pll_bringup_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .done(done), .busy(busy),
    .err_code(err_code)
);

// File: tb/pll_bringup_seq_test.sv
// Directed bench with a behavioural register target for the PLL sequencer.
module pll_bringup_seq_test;
    localparam int TMO = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0, stop_req = 1'b0, mode_sata = 1'b0;
    logic [2:0]  rate_sel = '0;
    logic        bus_valid, bus_write, bus_ready;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        done, busy;
    logic [1:0]  err_code;

    int n_chk = 0, n_err = 0;

    // Register target model.
    logic [31:0] r_stat, r_cfg1, r_cfg2, r_cfg3, r_cfg4;
    logic        auto_lock = 1'b0, auto_pd = 1'b0;
    logic [7:0]  wa [32];
    logic [31:0] wd [32];
    int          n_wr = 0, n_acc = 0, n_viol = 0;
    logic        pv_valid = 1'b0, pv_ready = 1'b0;
    logic [7:0]  pv_addr;
    logic [31:0] pv_wdata;

    pll_bringup_seq #(.TIMEOUT_CYCLES(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .mode_sata(mode_sata), .rate_sel(rate_sel),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .done(done), .busy(busy), .err_code(err_code)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] rd_reg(input logic [7:0] a);
        case (a)
            8'h04: rd_reg = r_stat;
            8'h0C: rd_reg = r_cfg1;
            8'h10: rd_reg = r_cfg2;
            8'h14: rd_reg = r_cfg3;
            8'h20: rd_reg = r_cfg4;
            default: rd_reg = 32'h0;
        endcase
    endfunction

    // Target: answer one cycle after valid, apply writes on completion.
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ready <= 1'b0;
            bus_rdata <= '0;
        end else if (bus_valid && !bus_ready) begin
            bus_ready <= 1'b1;
            bus_rdata <= rd_reg(bus_addr);
        end else begin
            bus_ready <= 1'b0;
            if (bus_valid && bus_ready) begin
                n_acc <= n_acc + 1;
                if (bus_write) begin
                    if (n_wr < 32) begin
                        wa[n_wr] <= bus_addr;
                        wd[n_wr] <= bus_wdata;
                    end
                    n_wr <= n_wr + 1;
                    case (bus_addr)
                        8'h08: if (bus_wdata == 32'h1 && auto_lock) r_stat[1] <= 1'b1;
                        8'h0C: r_cfg1 <= bus_wdata;
                        8'h10: begin
                            r_cfg2 <= bus_wdata;
                            if (r_cfg2[0] && !bus_wdata[0] && auto_lock) r_stat[1] <= 1'b1;
                            if (bus_wdata[0] && auto_pd) r_stat[16:15] <= 2'b11;
                        end
                        8'h14: r_cfg3 <= bus_wdata;
                        8'h20: r_cfg4 <= bus_wdata;
                        default: ;
                    endcase
                end
            end
        end
        // R2 monitor: a pending access must not change or vanish.
        if (rst_n && pv_valid && !pv_ready &&
            (!bus_valid || bus_addr != pv_addr || bus_wdata != pv_wdata))
            n_viol <= n_viol + 1;
        pv_valid <= bus_valid; pv_ready <= bus_ready;
        pv_addr  <= bus_addr;  pv_wdata <= bus_wdata;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Expected table from the requirements: {M, N, DCO, SD, fracM}.
    task automatic exp_cfg(input bit sata, input int r, output int m, output int n,
                           output int d, output int sd, output int f);
        int um[6] = '{1250, 3125, 1172, 1000, 1250, 3125};
        int un[6] = '{5, 20, 8, 7, 12, 47};
        int uf[6] = '{0, 0, 65537, 0, 0, 92843};
        int sm[6] = '{1000, 714, 625, 600, 461, 312};
        d = 4;
        if (sata) begin m = sm[r]; n = 7; sd = 6; f = 0; end
        else begin m = um[r]; n = un[r]; sd = (r == 3) ? 10 : 20; f = uf[r]; end
    endtask

    task automatic set_regs(input logic [31:0] s, c1, c2, c3, c4);
        @(negedge clk);
        r_stat = s; r_cfg1 = c1; r_cfg2 = c2; r_cfg3 = c3; r_cfg4 = c4;
        n_wr = 0; n_acc = 0;
    endtask

    // Issue a request and wait for done; checks pulse width and busy.
    task automatic run_req(input bit is_start, input bit sata, input logic [2:0] r, input string tag);
        int t = 0;
        @(negedge clk);
        mode_sata = sata; rate_sel = r;
        start_req = is_start; stop_req = !is_start;
        @(negedge clk);
        start_req = 1'b0; stop_req = 1'b0;
        check(busy || done, {tag, " R12 busy after accept"}, busy, 1);
        while (!done && t < 3000) begin @(negedge clk); t++; end
        check(done == 1'b1, {tag, " R12 done seen"}, done, 1);
        @(negedge clk);
        check(!done && !busy, {tag, " R12 done single cycle"}, {done, busy}, 0);
    endtask

    function automatic logic [31:0] rmw(input logic [31:0] old, input logic [31:0] mask, input int val, input int sh);
        return (old & ~mask) | ((32'(val) << sh) & mask);
    endfunction

    task automatic t_program(input bit sata, input int r, input string tag);
        int m, n, d, sd, f;
        logic [31:0] c1, c2;
        exp_cfg(sata, r, m, n, d, sd, f);
        auto_lock = 1'b1; auto_pd = 1'b0;
        set_regs(32'h0, 32'hA5A5_A5A5, 32'hFFFF_FFF0, 32'h5A5A_5A5A, 32'hFFFF_FFFF);
        run_req(1'b1, sata, 3'(r), tag);
        check(err_code == 2'd0, {tag, " R8 result ok"}, err_code, 0);
        check(n_wr == 6, {tag, " R6 write count"}, n_wr, 6);
        c1 = rmw(32'hA5A5_A5A5, 32'h0000_01FE, n, 1);
        c2 = rmw(32'hFFFF_FFF0, 32'h0000_000E, d, 1);
        check(wa[0] == 8'h0C && wd[0] == c1, {tag, " R6 R7 N step"}, wd[0], c1);
        check(wa[1] == 8'h10 && wd[1] == c2, {tag, " R6 R7 DCO step"}, wd[1], c2);
        c1 = rmw(c1, 32'h001F_FE00, m, 9);
        check(wa[2] == 8'h0C && wd[2] == c1, {tag, " R6 R7 M step"}, wd[2], c1);
        check(wa[3] == 8'h20 && wd[3] == rmw(32'hFFFF_FFFF, 32'h0003_FFFF, f, 0),
              {tag, " R6 R7 fracM step"}, wd[3], rmw(32'hFFFF_FFFF, 32'h0003_FFFF, f, 0));
        check(wa[4] == 8'h14 && wd[4] == rmw(32'h5A5A_5A5A, 32'h0003_FC00, sd, 10),
              {tag, " R6 R7 SD step"}, wd[4], rmw(32'h5A5A_5A5A, 32'h0003_FC00, sd, 10));
        check(wa[5] == 8'h08 && wd[5] == 32'h1, {tag, " R8 go write"}, wd[5], 1);
    endtask

    task automatic t_idle_exit();
        auto_lock = 1'b1;
        set_regs(32'h0, 32'h0, 32'h0000_0031, 32'h0, 32'h0);
        run_req(1'b1, 1'b0, 3'd0, "idle_exit");
        check(n_wr == 1, "R4 R5 one write only", n_wr, 1);
        check(wa[0] == 8'h10 && wd[0] == 32'h0000_0030, "R4 idle cleared, rest kept", wd[0], 32'h30);
        check(err_code == 2'd0, "R5 result ok", err_code, 0);
    endtask

    task automatic t_locked();
        auto_lock = 1'b1;
        set_regs(32'h2, 32'h0, 32'h0, 32'h0, 32'h0);
        run_req(1'b1, 1'b0, 3'd4, "locked");
        check(n_wr == 0, "R5 no writes when locked", n_wr, 0);
        check(n_acc == 2, "R5 cfg2 and status reads", n_acc, 2);
    endtask

    task automatic t_bad_rate();
        set_regs(32'h0, 32'h0, 32'h0, 32'h0, 32'h0);
        run_req(1'b1, 1'b0, 3'd7, "badrate");
        check(n_acc == 0, "R3 no bus access", n_acc, 0);
        check(err_code == 2'd1, "R3 invalid code", err_code, 1);
        run_req(1'b1, 1'b1, 3'd6, "badrate6");
        check(err_code == 2'd1 && n_acc == 0, "R3 code 6 invalid", err_code, 1);
    endtask

    task automatic t_lock_tmo();
        auto_lock = 1'b0;
        set_regs(32'h0, 32'h0, 32'h0, 32'h0, 32'h0);
        run_req(1'b1, 1'b0, 3'd1, "locktmo");
        check(err_code == 2'd2, "R8 lock timeout code", err_code, 2);
        check(n_wr == 6, "R8 programmed before timeout", n_wr, 6);
        repeat (5) @(negedge clk);
        check(err_code == 2'd2, "R12 code held", err_code, 2);
    endtask

    task automatic t_down_ok();
        auto_pd = 1'b1;
        set_regs(32'h2, 32'h0, 32'h0000_0040, 32'h0, 32'h0);
        run_req(1'b0, 1'b0, 3'd0, "down");
        check(n_wr == 1 && wa[0] == 8'h10 && wd[0] == 32'h41, "R9 idle set by rmw", wd[0], 32'h41);
        check(err_code == 2'd0, "R9 result ok", err_code, 0);
    endtask

    task automatic t_down_tmo();
        auto_pd = 1'b0;
        set_regs(32'h0000_8000, 32'h0, 32'h0, 32'h0, 32'h0);
        run_req(1'b0, 1'b0, 3'd0, "downtmo");
        check(err_code == 2'd3, "R10 power-down timeout", err_code, 3);
    endtask

    task automatic t_down_sata();
        set_regs(32'h0, 32'h0, 32'h0, 32'h0, 32'h0);
        run_req(1'b0, 1'b1, 3'd0, "downsata");
        check(n_acc == 0, "R11 no bus access", n_acc, 0);
        check(err_code == 2'd0, "R11 result ok and R12 cleared", err_code, 0);
    endtask

    initial begin : watchdog
        repeat (150_000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        r_stat = 0; r_cfg1 = 0; r_cfg2 = 0; r_cfg3 = 0; r_cfg4 = 0;
        repeat (3) @(negedge clk);
        check(!done && !busy && err_code == 0 && !bus_valid, "R1 reset state",
              {done, busy, err_code, bus_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !bus_valid, "R1 idle after reset", {busy, bus_valid}, 0);
        t_program(1'b0, 2, "usb19p2");
        t_program(1'b0, 5, "usb38p4");
        t_program(1'b0, 3, "usb20");
        t_program(1'b1, 4, "sata26");
        t_program(1'b1, 0, "sata12");
        t_idle_exit();
        t_locked();
        t_bad_rate();
        t_lock_tmo();
        t_down_ok();
        t_down_tmo();
        t_down_sata();
        check(n_viol == 0, "R2 handshake stable", n_viol, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule